// File: doc/BRIEF.md
# Packed Halfword Averaging Vector Unit

This block is a small SIMD execution unit that sits beside a scalar datapath. It owns a private file of eight 64-bit vector registers. It offers three operations: an average, a vector load and a vector store.

The average treats each register as four unsigned 16-bit lanes. It produces the truncated mean of matching lanes in a single cycle, and the halving is done by picking bits out of a carry-keeping sum. The load and store operations move a whole 64-bit vector between one register and a simple synchronous memory. That memory returns read data one cycle after the request.

One operation is issued per cycle through a valid strobe, a 2-bit operation code, three register indices and a memory address. Loaded data is forwarded to a reader in the same cycle it lands, so dependent operations can issue back to back without stalls.

Top module: `havg_vector_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, all eight vector registers become zero and any pending load is dropped; `mem_rd_en` and `mem_wr_en` are low whenever no operation is issued.
- R2: A register is four unsigned 16-bit lanes; lane k occupies bits 16k+15 down to 16k, so lane 0 is bits 15:0 and lane 3 is bits 63:48.
- R3: Each result lane equals bits 16:1 of the 17-bit sum of its two source lanes, with no carry into the next lane (0xFFFF with 0xFFFF gives 0xFFFF, 0x0001 with 0x0000 gives 0x0000, 0x8000 with 0x8000 gives 0x8000).
- R4: An average (op code 00) reads `op_src_a` and `op_src_b` and writes the destination at the clock edge ending its issue cycle, so an operation in the next cycle sees the result.
- R5: A load (op code 01) raises `mem_rd_en` with `mem_addr` equal to `op_addr` in its issue cycle; the memory answers on `mem_rdata` in the following cycle, and that word is written into `op_dst` at the edge ending that cycle.
- R6: A read of the register that a landing load writes in the same cycle returns the landing word, for both the store data and the average sources.
- R7: A store (op code 10) raises `mem_wr_en` in its issue cycle with `mem_addr` equal to `op_addr` and `mem_wdata` equal to register `op_src_a`.
- R8: If an average issued in the cycle after a load targets the same register as that load, the register keeps the average's result.
- R9: With `op_valid` low, or with op code 11, no memory strobe is raised and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_kind | input | 2 | 00 average, 01 load, 10 store, 11 none |
| op_src_a | input | 3 | First source register (store data source) |
| op_src_b | input | 3 | Second source register |
| op_dst | input | 3 | Destination register for average or load |
| op_addr | input | 8 | Memory word address for load or store |
| mem_addr | output | 8 | Memory word address |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_wdata | output | 64 | Store data |
| mem_rdata | input | 64 | Read data, valid one cycle after the request |

## Verification
The bench builds the unit with its default parameters: four 16-bit lanes, eight registers and an 8-bit word address. Random addresses are confined to sixteen words, so stores and later loads often hit the same word. With only eight registers, random back-to-back sequences often land a load on a register that the next average reads or overwrites. This reaches the bypass path and the write-collision ordering without directed setup. Lane values are drawn with bias toward 0x0000, 0x0001, 0x8000 and 0xFFFF, so that carry-out and truncation cases occur often in every lane.

// File: rtl/havg_pkg.sv
`timescale 1ns/1ps
// Package: operation codes shared by the averaging vector unit.
// Assumes a 2-bit operation field supplied with each issued operation.
package havg_pkg;
    typedef enum logic [1:0] {
        OP_AVG   = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_NONE  = 2'b11
    } vop_e;
endpackage

// File: rtl/havg_lanes.sv
`timescale 1ns/1ps
// Module: havg_lanes
// Lane-wise truncating average of two packed vectors. Each lane keeps a
// carry-out sum one bit wider than the lane and drops its low bit by
// selection. Purely combinational; assumes unsigned lane data.
module havg_lanes #(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    localparam int VEC_W = LANES * LANE_W
) (
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    output logic [VEC_W-1:0] vec_y
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] la;
        logic [LANE_W-1:0] lb;
        logic [LANE_W:0]   lsum;

        // Slice this lane and form its widened sum.
        always_comb begin
            la   = vec_a[g*LANE_W +: LANE_W];
            lb   = vec_b[g*LANE_W +: LANE_W];
            lsum = {1'b0, la} + {1'b0, lb};
        end

        assign vec_y[g*LANE_W +: LANE_W] = lsum[LANE_W:1];

        // R3: the mean of two lanes lies between the two inputs.
        always_comb begin
            if (!$isunknown({la, lb})) begin
                a_r3_mean_bounded: assert (
                    (vec_y[g*LANE_W +: LANE_W] >= ((la < lb) ? la : lb)) &&
                    (vec_y[g*LANE_W +: LANE_W] <= ((la < lb) ? lb : la)));
            end
        end
    end
endmodule

// File: rtl/havg_vrf.sv
`timescale 1ns/1ps
// Module: havg_vrf
// Vector register file with two read ports and two write ports: one for
// the average result, one for landing load data. The average port wins a
// same-index collision. Reads bypass the landing load data only; the
// average port is not bypassed because its data derives from the reads.
module havg_vrf #(
    parameter int ENTRIES = 8,
    parameter int VEC_W   = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [VEC_W-1:0] rd_a_data,
    output logic [VEC_W-1:0] rd_b_data,
    input  logic             cp_we,
    input  logic [IDX_W-1:0] cp_idx,
    input  logic [VEC_W-1:0] cp_data,
    input  logic             ld_we,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [VEC_W-1:0] ld_data
);
    logic [VEC_W-1:0] regs_q [ENTRIES];

    // Update storage: clear on reset, average port over load port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) regs_q[e] <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (cp_we && cp_idx == IDX_W'(e))      regs_q[e] <= cp_data;
                else if (ld_we && ld_idx == IDX_W'(e)) regs_q[e] <= ld_data;
            end
        end
    end

    // Read ports with forwarding of the landing load word.
    always_comb begin
        rd_a_data = (ld_we && ld_idx == rd_a_idx) ? ld_data : regs_q[rd_a_idx];
        rd_b_data = (ld_we && ld_idx == rd_b_idx) ? ld_data : regs_q[rd_b_idx];
    end

    // R4: an average result is held after the edge that writes it.
    a_r4_avg_commit: assert property (@(posedge clk) disable iff (!rst_n)
        cp_we |=> regs_q[$past(cp_idx)] == $past(cp_data));

    // R5: a landing load is held unless the average port took the entry.
    a_r5_load_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && !(cp_we && cp_idx == ld_idx)) |=>
            regs_q[$past(ld_idx)] == $past(ld_data));

    // R8: on a same-index collision the average result survives.
    a_r8_avg_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && cp_we && cp_idx == ld_idx) |=>
            regs_q[$past(cp_idx)] == $past(cp_data));
endmodule

// File: rtl/havg_vector_unit.sv
`timescale 1ns/1ps
// Module: havg_vector_unit
// Top of the packed halfword averaging unit: issue decode, load tracking,
// register file and lane datapath. Assumes one operation per cycle and a
// memory whose read data appears one cycle after the request.
module havg_vector_unit #(
    parameter int LANES   = 4,
    parameter int LANE_W  = 16,
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 8,
    localparam int VEC_W  = LANES * LANE_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [IDX_W-1:0]  op_src_a,
    input  logic [IDX_W-1:0]  op_src_b,
    input  logic [IDX_W-1:0]  op_dst,
    input  logic [ADDR_W-1:0] op_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [VEC_W-1:0]  mem_wdata,
    input  logic [VEC_W-1:0]  mem_rdata
);
    import havg_pkg::*;

    vop_e             kind;
    logic             is_avg, is_ld, is_st;
    logic             ld_pend_q;
    logic [IDX_W-1:0] ld_dst_q;
    logic [VEC_W-1:0] src_a_data, src_b_data, avg_data;

    // Decode the issued operation.
    always_comb begin
        kind   = vop_e'(op_kind);
        is_avg = op_valid && (kind == OP_AVG);
        is_ld  = op_valid && (kind == OP_LOAD);
        is_st  = op_valid && (kind == OP_STORE);
    end

    // Remember a load in flight until its data lands next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_pend_q <= 1'b0;
            ld_dst_q  <= '0;
        end else begin
            ld_pend_q <= is_ld;
            if (is_ld) ld_dst_q <= op_dst;
        end
    end

    havg_vrf #(.ENTRIES(ENTRIES), .VEC_W(VEC_W)) u_vrf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (op_src_a),
        .rd_b_idx  (op_src_b),
        .rd_a_data (src_a_data),
        .rd_b_data (src_b_data),
        .cp_we     (is_avg),
        .cp_idx    (op_dst),
        .cp_data   (avg_data),
        .ld_we     (ld_pend_q),
        .ld_idx    (ld_dst_q),
        .ld_data   (mem_rdata)
    );

    havg_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .vec_a (src_a_data),
        .vec_b (src_b_data),
        .vec_y (avg_data)
    );

    // Drive the memory request for loads and stores.
    always_comb begin
        mem_addr  = op_addr;
        mem_rd_en = is_ld;
        mem_wr_en = is_st;
        mem_wdata = src_a_data;
    end

    // R5: an issued load is pending next cycle with its destination.
    a_r5_load_pending: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ld_pend_q && ld_dst_q == $past(op_dst));

    // R9: an idle cycle leaves no load pending next cycle.
    a_r9_idle_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !ld_pend_q);

    // R7: read and write requests never coincide.
    a_r7_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
endmodule

// File: tb/havg_vector_unit_test.sv
`timescale 1ns/1ps
module havg_vector_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b11;
    logic [2:0]  op_src_a = '0, op_src_b = '0, op_dst = '0;
    logic [7:0]  op_addr = '0;
    logic [7:0]  mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [63:0] bmem [256];
    logic [63:0] shadow [8];

    always #4 clk = ~clk;

    havg_vector_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_src_a(op_src_a), .op_src_b(op_src_b), .op_dst(op_dst),
        .op_addr(op_addr), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Synchronous memory model: one cycle read latency.
    always @(posedge clk) begin
        if (mem_wr_en) bmem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= bmem[mem_addr];
    end

    function automatic logic [63:0] ref_avg(input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        for (int i = 0; i < 4; i++) begin
            logic [16:0] s;
            s = {1'b0, a[16*i +: 16]} + {1'b0, b[16*i +: 16]};
            r[16*i +: 16] = s[16:1];
        end
        return r;
    endfunction

    function automatic logic [15:0] pick_lane();
        case ($urandom_range(0, 7))
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h8000;
            3: return 16'hFFFF;
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    // Issue one operation at the current falling edge; checks happen 1 ns later.
    task automatic issue(input logic v, input logic [1:0] k, input logic [2:0] a,
                         input logic [2:0] b, input logic [2:0] d, input logic [7:0] ad);
        op_valid = v; op_kind = k; op_src_a = a; op_src_b = b; op_dst = d; op_addr = ad;
        #1;
        if (v && k == 2'b10) begin
            check("R7 store data", mem_wdata, shadow[a]);
            check("R7 store addr", {56'h0, mem_addr}, {56'h0, ad});
            check("R7 store strobe", {63'h0, mem_wr_en}, 64'h1);
        end else if (v && k == 2'b01) begin
            check("R5 load strobe", {63'h0, mem_rd_en}, 64'h1);
            check("R5 load addr", {56'h0, mem_addr}, {56'h0, ad});
        end else begin
            check("R9 no strobes", {62'h0, mem_rd_en, mem_wr_en}, 64'h0);
        end
        // Program-order model of the register file.
        if (v && k == 2'b00) shadow[d] = ref_avg(shadow[a], shadow[b]);
        if (v && k == 2'b01) shadow[d] = bmem[ad];
        @(negedge clk);
    endtask

    task automatic idle();
        issue(1'b0, 2'b00, 3'd0, 3'd0, 3'd0, 8'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired got=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] x;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) bmem[i] = {$urandom, $urandom};
        for (int i = 0; i < 8; i++) shadow[i] = '0;
        bmem[0] = 64'hFFFF_FFFF_0001_8000;
        bmem[1] = 64'hFFFF_0001_0000_8000;

        // R1: reset state.
        repeat (3) @(negedge clk);
        #1 check("R1 strobes in reset", {62'h0, mem_rd_en, mem_wr_en}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 8; r++) begin
            check("R1 cleared entry", shadow[r], 64'h0);
            issue(1'b1, 2'b10, 3'(r), 3'd0, 3'd0, 8'd200);
        end

        // R2/R3/R4/R6: corner lanes, with a bypassed source and an immediate store.
        issue(1'b1, 2'b01, 3'd0, 3'd0, 3'd1, 8'd0);
        issue(1'b1, 2'b01, 3'd0, 3'd0, 3'd2, 8'd1);
        issue(1'b1, 2'b00, 3'd1, 3'd2, 3'd3, 8'd0);   // r2 still landing: R6
        check("R3 corner lanes model", shadow[3], 64'hFFFF_8000_0000_8000);
        issue(1'b1, 2'b10, 3'd3, 3'd0, 3'd0, 8'd2);   // R4: next-cycle read
        issue(1'b1, 2'b10, 3'd2, 3'd0, 3'd0, 8'd3);   // R6 result already landed
        // R6: store reading a register in the cycle its load lands.
        issue(1'b1, 2'b01, 3'd0, 3'd0, 3'd5, 8'd0);
        issue(1'b1, 2'b10, 3'd5, 3'd0, 3'd0, 8'd4);
        check("R6 bypass store", bmem[4], 64'hFFFF_FFFF_0001_8000);

        // R8: load then average into the same register.
        issue(1'b1, 2'b01, 3'd0, 3'd0, 3'd4, 8'd1);
        issue(1'b1, 2'b00, 3'd1, 3'd1, 3'd4, 8'd0);
        issue(1'b1, 2'b10, 3'd4, 3'd0, 3'd0, 8'd5);
        check("R8 average kept", shadow[4], 64'hFFFF_FFFF_0001_8000);

        // R9: invalid strobe and reserved code leave registers alone.
        issue(1'b0, 2'b01, 3'd0, 3'd0, 3'd3, 8'd0);
        issue(1'b0, 2'b00, 3'd0, 3'd0, 3'd3, 8'd0);
        issue(1'b1, 2'b11, 3'd0, 3'd0, 3'd3, 8'd0);
        idle();
        issue(1'b1, 2'b10, 3'd3, 3'd0, 3'd0, 8'd6);
        check("R9 entry unchanged", bmem[6], 64'hFFFF_8000_0000_8000);

        // Random mixed traffic with lane-biased data.
        for (int i = 0; i < 16; i++) begin
            for (int l = 0; l < 4; l++) x[16*l +: 16] = pick_lane();
            bmem[i] = x;
        end
        for (int n = 0; n < 4000; n++) begin
            int sel;
            sel = $urandom_range(0, 9);
            issue(sel != 9,
                  (sel < 4) ? 2'b00 : (sel < 6) ? 2'b01 : (sel < 8) ? 2'b10 : 2'b11,
                  3'($urandom), 3'($urandom), 3'($urandom), 8'($urandom_range(0, 15)));
        end
        // R2/R3 final sweep: store every register against the model.
        for (int r = 0; r < 8; r++) issue(1'b1, 2'b10, 3'(r), 3'd0, 3'd0, 8'd100);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule